// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two bidirectional byte-wide buses, called side A and side B. It can pass a value straight across in either direction. It can also hold a copy of each side in its own storage register. Each register has its own capture clock and loads on that clock's rising edge. For each direction, a select input decides whether the driven bus carries the live value from the other bus or the value held in the register that samples the other bus.

An active-low enable and a direction input decide which bus the block drives. At most one bus is driven at a time. While the enable is inactive, neither bus is driven, but both registers still capture.

Each bus appears as three separate vectors: an input vector, an output vector and a per-bit output-enable vector. An outer pad ring can merge these into tristate pins. When a bus is not driven, the value on its output vector has no meaning.

Top module: `reg_bus_xcvr`

## Requirements
- R1: While `rstN` is low, both storage registers are cleared to zero asynchronously. After reset, selecting stored data with no capture edge drives zero.
- R2: On each rising edge of `capClkA`, the value on `busAIn` is loaded into the side-A register. No other event changes that register except reset.
- R3: On each rising edge of `capClkB`, the value on `busBIn` is loaded into the side-B register. No other event changes that register except reset.
- R4: When `selStoredToB` is 0, `busBOut` equals the live `busAIn`. When it is 1, `busBOut` equals the side-A register.
- R5: When `selStoredToA` is 0, `busAOut` equals the live `busBIn`. When it is 1, `busAOut` equals the side-B register.
- R6: With `enN` = 0, `dirAtoB` = 1 sets every bit of `busBOe` and clears every bit of `busAOe`. With `enN` = 0, `dirAtoB` = 0 does the reverse.
- R7: With `enN` = 1, every bit of both output-enable vectors is 0, and both registers keep capturing on their clock edges.
- R8: The output selection is purely combinational. A change of a select input shows on the driven bus with no clock edge, and it leaves both stored values unchanged.
- R9: `busAOe` and `busBOe` are never nonzero at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low clear of both registers |
| capClkA | input | 1 | Rising edge loads the side-A register from busAIn |
| capClkB | input | 1 | Rising edge loads the side-B register from busBIn |
| enN | input | 1 | Active-low output enable |
| dirAtoB | input | 1 | 1 drives bus B, 0 drives bus A (when enabled) |
| selStoredToB | input | 1 | Source for bus B: 0 live A, 1 stored A |
| selStoredToA | input | 1 | Source for bus A: 0 live B, 1 stored B |
| busAIn | input | W (8) | Value seen on bus A |
| busBIn | input | W (8) | Value seen on bus B |
| busAOut | output | W (8) | Value to drive onto bus A |
| busAOe | output | W (8) | Per-bit drive enable for bus A |
| busBOut | output | W (8) | Value to drive onto bus B |
| busBOe | output | W (8) | Per-bit drive enable for bus B |

## Verification
The register properties sample on each capture clock. They assume that bus data is steady at the rising edge of that clock, and that reset is released away from a capture edge.

The stimulus meets these assumptions. It changes bus values and selects only while both capture clocks are low. It raises a capture clock a quarter period later and releases reset between cycles.

The mux checks are immediate. They rely on the inputs being two-valued, so the stimulus never drives X or Z.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  // Strobes from the control decoder to the datapath
  typedef struct packed {
    logic driveA;
    logic driveB;
    logic storedToB;
    logic storedToA;
  } xcvr_strobe_t;
endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         enN,
  input  logic         dirAtoB,
  input  logic         selStoredToB,
  input  logic         selStoredToA,
  output xcvr_strobe_t strobe
);
  always_comb begin
    strobe.driveB    = ~enN & dirAtoB;
    strobe.driveA    = ~enN & ~dirAtoB;
    strobe.storedToB = selStoredToB;
    strobe.storedToA = selStoredToA;
  end

  // R7
  always_comb begin
    disabled_no_drive_chk: assert (!(enN && (strobe.driveA || strobe.driveB)))
      else $error("drive strobe raised while disabled");
  end
endmodule

// File: rtl/xcvr_dp.sv
module xcvr_dp
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rstN,
  input  logic         capClkA,
  input  logic         capClkB,
  input  xcvr_strobe_t strobe,
  input  logic [W-1:0] busAIn,
  input  logic [W-1:0] busBIn,
  output logic [W-1:0] busAOut,
  output logic [W-1:0] busAOe,
  output logic [W-1:0] busBOut,
  output logic [W-1:0] busBOe
);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] regA;
  logic [W-1:0] regB;

  always_ff @(posedge capClkA or negedge rstN) begin
    if (!rstN) regA <= ZERO;
    else       regA <= busAIn;
  end

  always_ff @(posedge capClkB or negedge rstN) begin
    if (!rstN) regB <= ZERO;
    else       regB <= busBIn;
  end

  // Per-bit output mux and enable fan-out
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_comb begin
      busBOut[i] = strobe.storedToB ? regA[i] : busAIn[i];
      busAOut[i] = strobe.storedToA ? regB[i] : busBIn[i];
      busBOe[i]  = strobe.driveB;
      busAOe[i]  = strobe.driveA;
    end
  end

  // R2
  capture_a_chk: assert property (@(posedge capClkA) disable iff (!rstN)
    1'b1 |=> (regA == $past(busAIn)))
    else $error("side-A register missed capture");

  // R3
  capture_b_chk: assert property (@(posedge capClkB) disable iff (!rstN)
    1'b1 |=> (regB == $past(busBIn)))
    else $error("side-B register missed capture");

  // R4
  always_comb begin
    live_to_b_chk: assert (strobe.storedToB || busBOut == busAIn)
      else $error("bus B not following live A");
  end

  // R5
  always_comb begin
    live_to_a_chk: assert (strobe.storedToA || busAOut == busBIn)
      else $error("bus A not following live B");
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         rstN,
  input  logic         capClkA,
  input  logic         capClkB,
  input  logic         enN,
  input  logic         dirAtoB,
  input  logic         selStoredToB,
  input  logic         selStoredToA,
  input  logic [W-1:0] busAIn,
  input  logic [W-1:0] busBIn,
  output logic [W-1:0] busAOut,
  output logic [W-1:0] busAOe,
  output logic [W-1:0] busBOut,
  output logic [W-1:0] busBOe
);
  xcvr_strobe_t strobe;

  xcvr_ctrl u_ctrl (
    .enN          (enN),
    .dirAtoB      (dirAtoB),
    .selStoredToB (selStoredToB),
    .selStoredToA (selStoredToA),
    .strobe       (strobe)
  );

  xcvr_dp #(.W(W)) u_dp (
    .rstN    (rstN),
    .capClkA (capClkA),
    .capClkB (capClkB),
    .strobe  (strobe),
    .busAIn  (busAIn),
    .busBIn  (busBIn),
    .busAOut (busAOut),
    .busAOe  (busAOe),
    .busBOut (busBOut),
    .busBOe  (busBOe)
  );

  // R9
  always_comb begin
    one_bus_driven_chk: assert (!(|busAOe && |busBOe))
      else $error("both buses driven");
  end

  // R6
  always_comb begin
    dir_select_chk: assert (enN || (dirAtoB ? (&busBOe && !(|busAOe))
                                            : (&busAOe && !(|busBOe))))
      else $error("direction does not match enables");
  end
endmodule

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  localparam int W = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rstN, capClkA, capClkB, enN, dirAtoB, selStoredToB, selStoredToA;
  logic [W-1:0] busAIn, busBIn, busAOut, busAOe, busBOut, busBOe;
  logic [W-1:0] mRegA, mRegB;
  int nChecks = 0;
  int nFails = 0;

  reg_bus_xcvr #(.W(W)) dut (.*);

  function automatic logic [W-1:0] expB();
    return selStoredToB ? mRegA : busAIn;
  endfunction
  function automatic logic [W-1:0] expA();
    return selStoredToA ? mRegB : busBIn;
  endfunction
  function automatic logic [W-1:0] expOe(input logic forB);
    logic d;
    d = !enN && (forB ? dirAtoB : !dirAtoB);
    return {W{d}};
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Full comparison of both buses; data only where the bus is driven
  task automatic checkAll(input string tag);
    check({tag, " R6/R7 oeA"}, busAOe, expOe(1'b0));
    check({tag, " R6/R7 oeB"}, busBOe, expOe(1'b1));
    check({tag, " R9 exclusive"}, {{(W-1){1'b0}}, (|busAOe && |busBOe)}, '0);
    if (expOe(1'b1)[0]) check({tag, " R4 busB"}, busBOut, expB());
    if (expOe(1'b0)[0]) check({tag, " R5 busA"}, busAOut, expA());
  endtask

  // One cycle: drive at posedge, optional capture edges at quarter period, check at negedge
  task automatic cycle(input logic en_n, input logic dir, input logic sB, input logic sA,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic ca, input logic cb, input string tag);
    @(posedge clk);
    capClkA = 1'b0; capClkB = 1'b0;
    enN = en_n; dirAtoB = dir; selStoredToB = sB; selStoredToA = sA;
    busAIn = a; busBIn = b;
    #(CLK_PERIOD/4);
    capClkA = ca; capClkB = cb;
    if (ca) mRegA = a;
    if (cb) mRegB = b;
    @(negedge clk);
    checkAll(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nFails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rstN = 1'b0; capClkA = 0; capClkB = 0; enN = 1; dirAtoB = 0;
    selStoredToB = 0; selStoredToA = 0; busAIn = '0; busBIn = '0;
    mRegA = '0; mRegB = '0;
    repeat (2) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: stored values are zero after reset
    cycle(0, 1, 1, 1, 8'hA5, 8'h5A, 0, 0, "R1 storedB");
    check("R1 busB zero", busBOut, '0);
    cycle(0, 0, 1, 1, 8'hA5, 8'h5A, 0, 0, "R1 storedA");
    check("R1 busA zero", busAOut, '0);

    // R7: capture while disabled, then read back
    cycle(1, 0, 0, 0, 8'h3C, 8'hC3, 1, 1, "R7 capture");
    cycle(0, 1, 1, 0, 8'hFF, 8'h00, 0, 0, "R2 read");
    check("R2 busB holds A", busBOut, 8'h3C);
    cycle(0, 0, 0, 1, 8'hFF, 8'h00, 0, 0, "R3 read");
    check("R3 busA holds B", busAOut, 8'hC3);

    // R8: select switched without clock edge, stored value undisturbed
    cycle(0, 1, 0, 0, 8'h81, 8'h18, 0, 0, "R8 live");
    check("R8 live", busBOut, 8'h81);
    #1 selStoredToB = 1'b1; #1;
    check("R8 switched", busBOut, 8'h3C);
    #1 selStoredToB = 1'b0; #1;
    check("R8 back", busBOut, 8'h81);

    // R2/R3 boundary: all-ones and alternating patterns
    cycle(0, 1, 1, 1, 8'hFF, 8'hAA, 1, 1, "R2 ones");
    cycle(0, 1, 1, 1, 8'h00, 8'h00, 0, 0, "R2 hold");
    check("R2 ones held", busBOut, 8'hFF);
    cycle(0, 0, 1, 1, 8'h00, 8'h00, 0, 0, "R3 hold");
    check("R3 alt held", busAOut, 8'hAA);

    // Random mix of all modes
    for (int i = 0; i < 2000; i++) begin
      cycle($urandom_range(0, 3) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
            $urandom_range(0, 1), W'($urandom), W'($urandom),
            $urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0, "rand");
    end

    // R1: reset in the middle clears registers
    @(posedge clk); #1 rstN = 1'b0; mRegA = '0; mRegB = '0;
    #2 rstN = 1'b1;
    cycle(0, 1, 1, 1, 8'h11, 8'h22, 0, 0, "R1 midreset");
    check("R1 midreset zero", busBOut, '0);

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule